// File: doc/BRIEF.md
# Paged Memory-Reference Address Unit

This unit works out the effective operand address of a memory-reference instruction for a word-addressed core. Memory words are 16 bits wide and addresses are 15 bits wide, so the address space holds 32K words. An instruction names a word in one of two ways. It can use page zero, or it can use the current page, which is the 1K-word page holding the program counter. An indirect flag makes the unit follow a chain of pointer words in memory until it finds a word whose top bit is clear.

The unit also handles subroutine linkage without a stack. A subroutine call writes the return address into the first word of the called routine, and execution then continues at the word after that one. A return is an indirect jump through that first word. It needs no special hardware, because it is simply a jump instruction with the indirect flag set.

The controller hands the unit one instruction word and its program counter on a valid/ready request channel. It takes the final address and the next program counter from a valid/ready result channel. While a result waits on the result channel, the request channel is closed. The result is held steady until `res_ready` is high on a rising edge, and no new request can enter before then. `busy` is high from the cycle after a request is accepted until the result has been taken. The memory port has a read enable, an address and read data, and read data arrives one cycle after the read is issued. The write enable and write data are used only for the return-address store.

Top module: `mref_addr_unit`

## Requirements
- R1: When instruction bit 10 is 0, the effective address is the 10-bit offset in bits 9:0 with the upper five address bits zero.
- R2: When instruction bit 10 is 1, the effective address is bits 14:10 of the program counter followed by the offset in bits 9:0.
- R3: When instruction bit 15 is 1, the unit reads the word at the formed address and takes bits 14:0 of that word as the new address. If bit 15 of that word is 1, it reads again at the new address. Each level costs exactly one read. A request with bit 15 clear makes no read.
- R4: Instruction bits 12:11 select the operation. With 00 or 11 (operand reference) the next program counter is PC+1. With 01 (jump) the next program counter is the effective address. Neither of these writes memory. Bits 14:13 have no effect.
- R5: With bits 12:11 = 10 (subroutine call), the unit writes {1'b0, PC+1} to the effective address, and the next program counter is the effective address plus one.
- R6: All program counter arithmetic wraps modulo 2^15: PC 0x7FFF gives a stored return address of 0x0000, and a call to 0x7FFF gives a next program counter of 0x0000.
- R7: A jump with bit 15 set through a routine's first word, after a call has stored into it, gives a next program counter equal to the stored return address.
- R8: `res_valid` rises 1 + N + S cycles after the accepting edge, where N is the number of indirect reads and S is 1 for a call and 0 otherwise.
- R9: While `res_valid` is high and `res_ready` is low, `res_ea` and `res_next_pc` hold still. `req_ready` stays low from acceptance until the result is taken, and `busy` is high over that span.
- R10: `mem_re` and `mem_we` are never high in the same cycle. A write happens only for a call, and the result appears one cycle after that write.
- R11: During and right after reset, `req_ready` is 1, and `res_valid`, `busy`, `mem_re` and `mem_we` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Unit can accept a request |
| req_instr | input | 16 | Instruction word |
| req_pc | input | 15 | Address of the instruction |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Controller takes the result |
| res_ea | output | 15 | Final effective address |
| res_next_pc | output | 15 | Next program counter |
| busy | output | 1 | Request in progress |
| mem_re | output | 1 | Memory read enable |
| mem_we | output | 1 | Memory write enable (return-address store) |
| mem_addr | output | 15 | Memory address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Read data, one cycle after `mem_re` |

## Verification
Each result is due a fixed number of cycles after the accepting edge. A direct request takes one cycle, and every indirect level and the return-address store each add one more cycle. The bench predicts that count for every request. It then counts falling edges from the accepting edge and requires `res_valid` on exactly the predicted one, reading the address and next program counter there. The bench model counts memory reads and writes per request and compares them with the indirection depth and the operation. Back-pressure checks sample the outputs on every falling edge of a stall.

// File: rtl/mref_pkg.sv
package mref_pkg;
  localparam int ADDR_W   = 15;
  localparam int DATA_W   = 16;
  localparam int OFS_W    = 10;
  localparam int PAGE_W   = ADDR_W - OFS_W;
  localparam int IND_BIT  = 15;
  localparam int PSEL_BIT = 10;
  localparam int OP_LO    = 11;
  localparam int OP_W     = 2;

  typedef enum logic [OP_W-1:0] {
    OP_OPND  = 2'b00,
    OP_JMP   = 2'b01,
    OP_CALL  = 2'b10,
    OP_OPND2 = 2'b11
  } mref_op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CHASE = 2'd1,
    ST_STORE = 2'd2,
    ST_DONE  = 2'd3
  } mref_state_e;
endpackage

// File: rtl/mref_page_form.sv
module mref_page_form #(
  parameter int ADDR_W = mref_pkg::ADDR_W,
  parameter int OFS_W  = mref_pkg::OFS_W
) (
  input  logic [OFS_W-1:0]  ofs,
  input  logic              psel,
  input  logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] ea
);
  localparam int PAGE_W = ADDR_W - OFS_W;
  logic [PAGE_W-1:0] page;

  always_comb begin
    if (psel) page = pc[ADDR_W-1 -: PAGE_W];
    else      page = '0;
    ea = {page, ofs};
  end
endmodule

// File: rtl/mref_link_calc.sv
module mref_link_calc #(
  parameter int ADDR_W = mref_pkg::ADDR_W,
  parameter int DATA_W = mref_pkg::DATA_W
) (
  input  mref_pkg::mref_op_e op,
  input  logic [ADDR_W-1:0]  pc,
  input  logic [ADDR_W-1:0]  ea,
  output logic [ADDR_W-1:0]  next_pc,
  output logic [DATA_W-1:0]  ret_word
);
  logic [ADDR_W-1:0] pc_inc;
  logic [ADDR_W-1:0] ea_inc;

  always_comb begin
    pc_inc   = pc + 1'b1;
    ea_inc   = ea + 1'b1;
    ret_word = DATA_W'(pc_inc);
    case (op)
      mref_pkg::OP_JMP:  next_pc = ea;
      mref_pkg::OP_CALL: next_pc = ea_inc;
      default:           next_pc = pc_inc;
    endcase
  end
endmodule

// File: rtl/mref_seq.sv
module mref_seq #(
  parameter int ADDR_W = mref_pkg::ADDR_W,
  parameter int DATA_W = mref_pkg::DATA_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic                   start_ind,
  input  logic                   start_call,
  input  logic [ADDR_W-1:0]      start_ea,
  input  logic                   call_q,
  input  logic [DATA_W-1:0]      rdata,
  input  logic                   res_take,
  output mref_pkg::mref_state_e  state,
  output logic [ADDR_W-1:0]      ea_q,
  output logic                   rd_en,
  output logic [ADDR_W-1:0]      rd_addr
);
  import mref_pkg::*;

  mref_state_e       state_d;
  logic [ADDR_W-1:0] ea_d;
  logic              more;

  assign more = rdata[DATA_W-1];

  always_comb begin
    state_d = state;
    ea_d    = ea_q;
    rd_en   = 1'b0;
    rd_addr = start_ea;
    case (state)
      ST_IDLE: begin
        if (start) begin
          if (start_ind) begin
            rd_en   = 1'b1;
            state_d = ST_CHASE;
          end else begin
            ea_d    = start_ea;
            state_d = start_call ? ST_STORE : ST_DONE;
          end
        end
      end
      ST_CHASE: begin
        if (more) begin
          rd_en   = 1'b1;
          rd_addr = rdata[ADDR_W-1:0];
        end else begin
          ea_d    = rdata[ADDR_W-1:0];
          state_d = call_q ? ST_STORE : ST_DONE;
        end
      end
      ST_STORE: state_d = ST_DONE;
      ST_DONE:  if (res_take) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      ea_q  <= '0;
    end else begin
      state <= state_d;
      ea_q  <= ea_d;
    end
  end
endmodule

// File: rtl/mref_addr_unit.sv
module mref_addr_unit #(
  parameter int ADDR_W = mref_pkg::ADDR_W,
  parameter int DATA_W = mref_pkg::DATA_W,
  parameter int OFS_W  = mref_pkg::OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [DATA_W-1:0] req_instr,
  input  logic [ADDR_W-1:0] req_pc,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [ADDR_W-1:0] res_ea,
  output logic [ADDR_W-1:0] res_next_pc,
  output logic              busy,
  output logic              mem_re,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);
  import mref_pkg::*;

  mref_state_e       state;
  mref_op_e          op_in;
  mref_op_e          op_q;
  logic [ADDR_W-1:0] pc_q;
  logic [ADDR_W-1:0] ea_q;
  logic [ADDR_W-1:0] direct_ea;
  logic [ADDR_W-1:0] rd_addr;
  logic [DATA_W-1:0] ret_word;
  logic              rd_en;
  logic              accept;

  assign op_in     = mref_op_e'(req_instr[OP_LO +: OP_W]);
  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign res_valid = (state == ST_DONE);
  assign busy      = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q <= OP_OPND;
      pc_q <= '0;
    end else if (accept) begin
      op_q <= op_in;
      pc_q <= req_pc;
    end
  end

  mref_page_form #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_page (
    .ofs  (req_instr[OFS_W-1:0]),
    .psel (req_instr[PSEL_BIT]),
    .pc   (req_pc),
    .ea   (direct_ea)
  );

  mref_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (accept),
    .start_ind  (req_instr[IND_BIT]),
    .start_call (op_in == OP_CALL),
    .start_ea   (direct_ea),
    .call_q     (op_q == OP_CALL),
    .rdata      (mem_rdata),
    .res_take   (res_ready),
    .state      (state),
    .ea_q       (ea_q),
    .rd_en      (rd_en),
    .rd_addr    (rd_addr)
  );

  mref_link_calc #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_link (
    .op       (op_q),
    .pc       (pc_q),
    .ea       (ea_q),
    .next_pc  (res_next_pc),
    .ret_word (ret_word)
  );

  assign mem_we    = (state == ST_STORE);
  assign mem_re    = rd_en;
  assign mem_addr  = mem_we ? ea_q : rd_addr;
  assign mem_wdata = ret_word;
  assign res_ea    = ea_q;
endmodule

// File: rtl/mref_addr_unit_chk.sv
module mref_addr_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic [15:0] req_instr,
  input logic [14:0] req_pc,
  input logic        res_valid,
  input logic        res_ready,
  input logic [14:0] res_ea,
  input logic [14:0] res_next_pc,
  input logic        busy,
  input logic        mem_re,
  input logic        mem_we,
  input logic [14:0] mem_addr,
  input logic [15:0] mem_wdata,
  input logic [15:0] mem_rdata
);
  // R10
  mem_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_re && mem_we));

  // R10
  store_then_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> res_valid && (res_ea == $past(mem_addr))
               && (res_next_pc == 15'($past(mem_addr) + 15'd1)));

  // R9
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> res_valid && $stable(res_ea) && $stable(res_next_pc));

  // R9
  req_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !req_ready && busy);

  // R8
  direct_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_instr[15] && req_instr[12:11] != 2'b10) |=> res_valid);

  // R3
  direct_noread_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_instr[15]) |-> !mem_re);

  // R11
  reset_state_chk: assert property (@(posedge clk)
    !rst_n |=> req_ready && !res_valid && !busy && !mem_re && !mem_we);
endmodule

bind mref_addr_unit mref_addr_unit_chk u_chk (.*);

// File: tb/mref_addr_unit_bench.sv
module mref_addr_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_instr = '0;
  logic [14:0] req_pc = '0;
  logic        res_valid;
  logic        res_ready = 1'b0;
  logic [14:0] res_ea;
  logic [14:0] res_next_pc;
  logic        busy;
  logic        mem_re;
  logic        mem_we;
  logic [14:0] mem_addr;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata = '0;

  int checks = 0;
  int fails  = 0;
  int rd_cnt = 0;
  int wr_cnt = 0;
  logic [14:0] last_wa = '0;
  logic [15:0] last_wd = '0;
  logic [15:0] mem [int];

  always #5 clk = ~clk;

  mref_addr_unit u_mref_addr_unit (.*);

  always @(posedge clk) begin
    if (mem_re) begin
      mem_rdata <= mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 16'h0000;
      rd_cnt = rd_cnt + 1;
    end
    if (mem_we) begin
      mem[int'(mem_addr)] = mem_wdata;
      wr_cnt  = wr_cnt + 1;
      last_wa = mem_addr;
      last_wd = mem_wdata;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] mk(input bit ind, input logic [1:0] op,
                                     input bit psel, input logic [9:0] ofs,
                                     input logic [1:0] hi);
    return {ind, hi, op, psel, ofs};
  endfunction

  function automatic logic [14:0] exp_npc(input logic [1:0] op, input logic [14:0] pc,
                                          input logic [14:0] ea);
    if (op == 2'b01) return ea;
    if (op == 2'b10) return 15'(ea + 15'd1);
    return 15'(pc + 15'd1);
  endfunction

  task automatic run(input logic [15:0] instr, input logic [14:0] pc,
                     input logic [14:0] eea, input int nrd, input string tag);
    int lat;
    int r0;
    int w0;
    logic [1:0] op;
    logic [14:0] enpc;
    int elat;
    op   = instr[12:11];
    enpc = exp_npc(op, pc, eea);
    elat = 1 + nrd + ((op == 2'b10) ? 1 : 0);
    @(negedge clk);
    chk(req_ready == 1'b1, {tag, " R9 ready before request"}, int'(req_ready), 1);
    req_instr = instr; req_pc = pc; req_valid = 1'b1; res_ready = 1'b1;
    r0 = rd_cnt; w0 = wr_cnt;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!res_valid && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    chk(lat == elat, {tag, " R8 latency"}, lat, elat);
    chk(res_ea == eea, {tag, " R1/R2/R3 effective address"}, int'(res_ea), int'(eea));
    chk(res_next_pc == enpc, {tag, " R4/R5/R6 next pc"}, int'(res_next_pc), int'(enpc));
    chk(rd_cnt - r0 == nrd, {tag, " R3 read count"}, rd_cnt - r0, nrd);
    if (op == 2'b10) begin
      chk(wr_cnt - w0 == 1, {tag, " R5 one write"}, wr_cnt - w0, 1);
      chk(last_wa == eea && last_wd == {1'b0, 15'(pc + 15'd1)}, {tag, " R5/R6 stored word"},
          int'(last_wd), int'({1'b0, 15'(pc + 15'd1)}));
    end else begin
      chk(wr_cnt == w0, {tag, " R4/R10 no write"}, wr_cnt - w0, 0);
    end
    @(posedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R8 actual=hung expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(req_ready && !res_valid && !busy && !mem_re && !mem_we, "R11 reset outputs",
        {req_ready, res_valid, busy, mem_re, mem_we}, 5'b10000);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !res_valid && !busy, "R11 after reset", {req_ready, res_valid, busy}, 3'b100);

    // R1 R2 R4 R5 R6: sweep of pages, offsets, page select and operation
    for (int pg = 0; pg < 32; pg++) begin
      for (int oi = 0; oi < 4; oi++) begin
        for (int ps = 0; ps < 2; ps++) begin
          for (int op = 0; op < 4; op++) begin
            logic [9:0]  ofs;
            logic [14:0] pc;
            logic [14:0] ea;
            ofs = (oi == 0) ? 10'h000 : (oi == 1) ? 10'h001 : (oi == 2) ? 10'h155 : 10'h3FF;
            pc  = {5'(pg), 10'((pg * 37 + oi * 101) & 10'h3FF)};
            if (pg == 31 && oi == 3) pc = 15'h7FFF;
            ea  = ps ? {5'(pg), ofs} : {5'd0, ofs};
            run(mk(1'b0, 2'(op), ps[0], ofs, 2'(pg)), pc, ea, 0,
                ps ? "R2 sweep" : "R1 sweep");
          end
        end
      end
    end

    // R3 R8: indirect chains of depth 1 to 4 under every operation
    for (int n = 1; n <= 4; n++) begin
      for (int op = 0; op < 3; op++) begin
        logic [14:0] a0;
        logic [14:0] fin;
        a0  = {5'd3, 10'(10'h100 + n)};
        fin = 15'(15'h2222 + n * 16 + op);
        for (int k = 0; k < n; k++) begin
          logic [14:0] here;
          logic [14:0] nxt;
          here = (k == 0) ? a0 : 15'(15'h5000 + n * 16 + k);
          nxt  = (k == n - 1) ? fin : 15'(15'h5000 + n * 16 + k + 1);
          mem[int'(here)] = {(k != n - 1), nxt};
        end
        run(mk(1'b1, 2'(op), 1'b1, 10'(10'h100 + n), 2'b00), 15'h0C44, fin, n,
            "R3 indirect chain");
      end
    end

    // R6 wrap of return address and of call target
    run(mk(1'b0, 2'b10, 1'b0, 10'h020, 2'b00), 15'h7FFF, 15'h0020, 0, "R6 return wraps");
    run(mk(1'b0, 2'b10, 1'b1, 10'h3FF, 2'b00), 15'h7C05, 15'h7FFF, 0, "R6 target wraps");

    // R7 call then return through the first word
    run(mk(1'b0, 2'b10, 1'b0, 10'h200, 2'b00), 15'h1234, 15'h0200, 0, "R7 call");
    run(mk(1'b1, 2'b01, 1'b0, 10'h200, 2'b00), 15'h0210, 15'h1235, 1, "R7 return");

    // R9 back-pressure: result held, request channel closed
    @(negedge clk);
    req_instr = mk(1'b0, 2'b01, 1'b1, 10'h0AB, 2'b00); req_pc = 15'h4C00;
    req_valid = 1'b1; res_ready = 1'b0;
    @(negedge clk);
    req_instr = mk(1'b0, 2'b00, 1'b0, 10'h011, 2'b00); req_pc = 15'h0001;
    for (int i = 0; i < 5; i++) begin
      chk(res_valid && !req_ready && busy, "R9 stalled flags",
          {res_valid, req_ready, busy}, 3'b101);
      chk(res_ea == 15'h4CAB && res_next_pc == 15'h4CAB, "R9 held result",
          int'(res_ea), 15'h4CAB);
      @(negedge clk);
    end
    req_valid = 1'b0; res_ready = 1'b1;
    @(negedge clk);
    chk(req_ready && !res_valid && !busy, "R9 released", {req_ready, res_valid, busy}, 3'b100);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule